// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock into one slower output whose high time and low time are set independently, each in whole input-clock cycles. Four-bit count fields give each half of the period a length from 1 to 16 input cycles. Uneven duty cycles and odd division ratios need no extra logic.

A shared, chip-level restart input lets many copies of the divider begin counting on the same input edge. While restart is applied, each copy holds its output at a chosen start level and clears its counters. When restart is released, each copy waits its own programmed offset before it begins toggling, so the outputs line up with known phase relationships. A copy can be told to ignore restart. Once it ignores restart, it can also be pinned statically to its start level. A bypass control idles the counting logic and passes the input clock straight to the output.

Count changes are absorbed only at a phase boundary, so a reconfiguration never produces a shortened pulse.

Top module: `clk_div_prog`

## Requirements
- R1: With bypass and force inactive and restart released, every high phase after the first toggle lasts exactly `hi_cnt_i`+1 input cycles.
- R2: Under the same conditions, every low phase after the first toggle lasts exactly `lo_cnt_i`+1 input cycles.
- R3: The restart input passes through one register. While restart is asserted and not ignored, `clk_o` sits at the start level from the second rising edge after `sync_i` is sampled high, and the counters are cleared.
- R4: Let E0 be the first rising edge that samples `sync_i` low after a held restart. The first change of `clk_o` happens at edge E0 + `phase_i` + N + 2, where N is the count field of the start phase. Several copies that share `sync_i` follow this rule from the same E0.
- R5: `start_hi_i` = 1 makes the output begin high and use `hi_cnt_i` for its first phase. `start_hi_i` = 0 makes it begin low and use `lo_cnt_i`.
- R6: While `force_i` and `ign_sync_i` are both 1 and bypass is 0, `clk_o` equals `start_hi_i` on every cycle.
- R7: While `ign_sync_i` is 0, `force_i` has no effect on `clk_o`.
- R8: While `ign_sync_i` is 1, asserting `sync_i` does not interrupt the toggling of `clk_o`.
- R9: While `bypass_i` is 1, `clk_o` equals `clk_i` and the counting logic is held idle with its counters cleared.
- R10: A new `hi_cnt_i` or `lo_cnt_i` value is taken only when a phase of that kind begins. A phase already in progress keeps its old length.
- R11: While `rst_ni` is low and bypass is 0, `clk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Chip-level restart, active high |
| hi_cnt_i | input | CNT_W | High phase length minus one |
| lo_cnt_i | input | CNT_W | Low phase length minus one |
| phase_i | input | CNT_W | Input cycles to wait after restart release |
| start_hi_i | input | 1 | Start level: 1 high, 0 low |
| force_i | input | 1 | Pin output to start level (needs ign_sync_i) |
| ign_sync_i | input | 1 | Ignore the restart input |
| bypass_i | input | 1 | Route clk_i to output, idle the counters |
| clk_o | output | 1 | Divided clock |

## Verification
Several properties are checked on every cycle. The output follows the start level two edges into a held restart. A forced output matches the start level. Bypass leaves the counters cleared. No phase while running lasts longer than 16 cycles.

Other behaviours can only be shown by the bench's scenarios, which compare a full output trace against a model built from the requirements. These are the exact high and low widths, the release offset and its alignment across two copies with different settings, and the deferred take-up of new counts. The scenarios also cover restart being ignored, force having no effect without ignore, and the bypass clock pass-through.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } div_st_e;
endpackage

// File: rtl/clk_div_sync.sv
module clk_div_sync #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g+1] <= 1'b0;
      else         chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/clk_div_core.sv
module clk_div_core
  import clk_div_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             start_hi_i,
  output logic             lvl_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);
  div_st_e          st_q;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] wcnt_q;
  logic [CNT_W-1:0] cur_len;
  logic [CNT_W-1:0] next_len;

  // length of the phase currently held, and of the one that follows it
  assign cur_len  = lvl_q ? hi_cnt_i : lo_cnt_i;
  assign next_len = lvl_q ? lo_cnt_i : hi_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      wcnt_q <= '0;
    end else if (hold_i) begin
      st_q   <= ST_HOLD;
      lvl_q  <= start_hi_i;
      cnt_q  <= '0;
      len_q  <= start_hi_i ? hi_cnt_i : lo_cnt_i;
      wcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          len_q <= cur_len;
          if (phase_i == '0) begin
            st_q <= ST_RUN;
          end else begin
            st_q   <= ST_WAIT;
            wcnt_q <= phase_i - 1'b1;
          end
        end
        ST_WAIT: begin
          len_q <= cur_len;
          if (wcnt_q == '0) st_q <= ST_RUN;
          else              wcnt_q <= wcnt_q - 1'b1;
        end
        ST_RUN: begin
          if (cnt_q == len_q) begin
            lvl_q <= ~lvl_q;
            cnt_q <= '0;
            len_q <= next_len;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_HOLD;
      endcase
    end
  end

  assign lvl_o = lvl_q;
  assign run_o = (st_q == ST_RUN);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/clk_div_outmux.sv
module clk_div_outmux (
  input  logic clk_i,
  input  logic lvl_i,
  input  logic start_hi_i,
  input  logic pin_i,
  input  logic bypass_i,
  output logic clk_o
);
  always_comb begin
    if (bypass_i)   clk_o = clk_i;
    else if (pin_i) clk_o = start_hi_i;
    else            clk_o = lvl_i;
  end
endmodule

// File: rtl/clk_div_prog.sv
module clk_div_prog #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             start_hi_i,
  input  logic             force_i,
  input  logic             ign_sync_i,
  input  logic             bypass_i,
  output logic             clk_o
);
  logic             sync_q;
  logic             core_hold;
  logic             core_lvl;
  logic             core_run;
  logic [CNT_W-1:0] core_cnt;
  logic             pin_lvl;

  clk_div_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_i),
    .q_o   (sync_q)
  );

  assign core_hold = (sync_q & ~ign_sync_i) | bypass_i;
  assign pin_lvl   = force_i & ign_sync_i;

  clk_div_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (core_hold),
    .hi_cnt_i  (hi_cnt_i),
    .lo_cnt_i  (lo_cnt_i),
    .phase_i   (phase_i),
    .start_hi_i(start_hi_i),
    .lvl_o     (core_lvl),
    .run_o     (core_run),
    .cnt_o     (core_cnt)
  );

  clk_div_outmux u_mux (
    .clk_i     (clk_i),
    .lvl_i     (core_lvl),
    .start_hi_i(start_hi_i),
    .pin_i     (pin_lvl),
    .bypass_i  (bypass_i),
    .clk_o     (clk_o)
  );
endmodule

// File: rtl/clk_div_prog_chk.sv
module clk_div_prog_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             start_hi_i,
  input logic             force_i,
  input logic             ign_sync_i,
  input logic             bypass_i,
  input logic             clk_o,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam int LEN_W   = CNT_W + 2;
  localparam int MAX_LEN = 2 ** CNT_W;

  logic [1:0]       age_q;
  logic [LEN_W-1:0] run_len_q;
  logic             prev_q;
  logic             free_run;

  assign free_run = run_i && !bypass_i && !(force_i && ign_sync_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q     <= '0;
      run_len_q <= '0;
      prev_q    <= 1'b0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
      prev_q <= clk_o;
      if (!free_run)                 run_len_q <= '0;
      else if (clk_o != prev_q)      run_len_q <= LEN_W'(1);
      else if (run_len_q != '1)      run_len_q <= run_len_q + 1'b1;
    end
  end

  // R3: output at start level once the registered restart has acted
  p_sync_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(sync_i, 2) && !$past(ign_sync_i) && !ign_sync_i
     && !bypass_i && !force_i && ($past(start_hi_i) == start_hi_i))
    |-> (clk_o == start_hi_i));

  // R6
  p_force_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && ign_sync_i && !bypass_i) |-> (clk_o == start_hi_i));

  // R9: counting logic idle while bypassed
  p_bypass_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (!run_i && cnt_i == '0));

  // R1, R2: no running phase exceeds the longest programmable length
  p_phase_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len_q <= LEN_W'(MAX_LEN));

  // R11
  always_ff @(posedge clk_i) begin
    if (rst_ni === 1'b0 && bypass_i === 1'b0)
      p_reset_low_r11: assert (clk_o == 1'b0);
  end
endmodule

bind clk_div_prog clk_div_prog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_i    (sync_i),
  .start_hi_i(start_hi_i),
  .force_i   (force_i),
  .ign_sync_i(ign_sync_i),
  .bypass_i  (bypass_i),
  .clk_o     (clk_o),
  .run_i     (core_run),
  .cnt_i     (core_cnt)
);

// File: tb/clk_div_prog_tb.sv
`timescale 1ns/1ps
module clk_div_prog_tb;
  localparam int NS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic [3:0] a_hi = '0, a_lo = '0, a_ph = '0;
  logic [3:0] b_hi = '0, b_lo = '0, b_ph = '0;
  logic a_st = 0, a_frc = 0, a_ign = 0, a_byp = 0;
  logic b_st = 0, b_frc = 0, b_ign = 0, b_byp = 0;
  logic clk_a, clk_b;

  int n_run = 0;
  int n_fail = 0;
  logic ra [NS];
  logic rb [NS];

  always #4 clk = ~clk;

  clk_div_prog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync),
    .hi_cnt_i(a_hi), .lo_cnt_i(a_lo), .phase_i(a_ph),
    .start_hi_i(a_st), .force_i(a_frc), .ign_sync_i(a_ign),
    .bypass_i(a_byp), .clk_o(clk_a)
  );

  clk_div_prog u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync),
    .hi_cnt_i(b_hi), .lo_cnt_i(b_lo), .phase_i(b_ph),
    .start_hi_i(b_st), .force_i(b_frc), .ign_sync_i(b_ign),
    .bypass_i(b_byp), .clk_o(clk_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_lvl(int j, int p, int hi, int lo, logic st);
    int ns = st ? hi : lo;
    int no = st ? lo : hi;
    int t  = p + 2 + ns;
    logic lv = st;
    while (t <= j) begin
      lv = ~lv;
      t += ((lv == st) ? ns : no) + 1;
    end
    return lv;
  endfunction

  task automatic capture();
    for (int j = 0; j < NS; j++) begin
      @(negedge clk);
      ra[j] = clk_a;
      rb[j] = clk_b;
    end
  endtask

  task automatic restart_release();
    @(negedge clk);
    sync = 1'b1;
    repeat (4) @(negedge clk);
    sync = 1'b0;
  endtask

  // R1 R2 R4 R5 (R7 when force is set on a): traces of both copies after a shared restart
  task automatic t_pattern(input int pa, ha, la, input logic sa,
                           input int pb, hb, lb, input logic sb, input string req);
    int bad_a = -1, bad_b = -1;
    @(negedge clk);
    a_ph = 4'(pa); a_hi = 4'(ha); a_lo = 4'(la); a_st = sa;
    b_ph = 4'(pb); b_hi = 4'(hb); b_lo = 4'(lb); b_st = sb;
    restart_release();
    capture();
    for (int j = NS - 1; j >= 0; j--) begin
      if (ra[j] !== exp_lvl(j, pa, ha, la, sa)) bad_a = j;
      if (rb[j] !== exp_lvl(j, pb, hb, lb, sb)) bad_b = j;
    end
    chk(bad_a < 0, req, "copy a first bad sample index", bad_a, -1);
    chk(bad_b < 0, req, "copy b first bad sample index", bad_b, -1);
  endtask

  task automatic t_reset();
    #20;
    chk(clk_a === 1'b0, "R11", "clk_a in reset", int'(clk_a), 0);
    chk(clk_b === 1'b0, "R11", "clk_b in reset", int'(clk_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R3: held restart pins the start level
  task automatic t_sync_hold();
    int bad = -1;
    @(negedge clk);
    a_hi = 4'd2; a_lo = 4'd2; a_ph = 4'd0; a_st = 1'b1;
    sync = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 1 && clk_a !== 1'b1 && bad < 0) bad = j;
    end
    chk(bad < 0, "R3", "held-restart sample not at start level", bad, -1);
    sync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // R8: ignored restart leaves toggling running
  task automatic t_ignore();
    int toggles = 0;
    logic prev;
    @(negedge clk);
    a_hi = 4'd0; a_lo = 4'd0; a_ign = 1'b1;
    repeat (3) @(negedge clk);
    prev = clk_a;
    sync = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (clk_a !== prev) toggles++;
      prev = clk_a;
    end
    sync = 1'b0;
    chk(toggles == 10, "R8", "toggles during ignored restart", toggles, 10);
  endtask

  // R6: force with ignore pins both start levels
  task automatic t_force();
    int bad;
    for (int s = 0; s < 2; s++) begin
      bad = 0;
      @(negedge clk);
      a_ign = 1'b1; a_frc = 1'b1; a_st = s[0];
      for (int j = 0; j < 12; j++) begin
        @(negedge clk);
        if (clk_a !== s[0]) bad++;
      end
      chk(bad == 0, "R6", "forced samples off start level", bad, 0);
    end
    @(negedge clk);
    a_frc = 1'b0; a_ign = 1'b0;
  endtask

  // R9: bypass routes input clock through
  task automatic t_bypass();
    int bad = 0;
    @(negedge clk);
    a_byp = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(posedge clk); #2;
      if (clk_a !== 1'b1) bad++;
      @(negedge clk); #2;
      if (clk_a !== 1'b0) bad++;
    end
    chk(bad == 0, "R9", "bypass samples differing from clk_i", bad, 0);
    @(negedge clk);
    a_byp = 1'b0;
  endtask

  // R10: count change mid-phase keeps the running phase intact
  task automatic t_reconfig();
    logic exp [30];
    int bad = -1;
    for (int j = 0; j < 30; j++)
      exp[j] = (j < 7) ? 1'b1 : (j < 13) ? 1'b0 : (j < 19) ? 1'b1 :
               (j < 22) ? 1'b0 : (j < 24) ? 1'b1 : (j < 27) ? 1'b0 :
               (j < 29) ? 1'b1 : 1'b0;
    @(negedge clk);
    a_hi = 4'd5; a_lo = 4'd5; a_ph = 4'd0; a_st = 1'b1;
    restart_release();
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      ra[j] = clk_a;
      if (j == 14) begin a_hi = 4'd1; a_lo = 4'd2; end
    end
    for (int j = 29; j >= 0; j--) if (ra[j] !== exp[j]) bad = j;
    chk(bad < 0, "R10", "reconfig trace first bad sample index", bad, -1);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_pattern(0, 0, 0, 1'b0,   3, 2, 1, 1'b1,   "R4");
    t_pattern(5, 7, 3, 1'b1,   0, 1, 6, 1'b0,   "R1");
    t_pattern(15, 15, 15, 1'b0, 2, 0, 4, 1'b1,  "R2");
    t_pattern(1, 3, 0, 1'b1,   4, 0, 3, 1'b0,   "R5");
    t_sync_hold();
    t_ignore();
    t_force();
    a_frc = 1'b1; a_ign = 1'b0;
    t_pattern(2, 4, 1, 1'b1,   1, 2, 2, 1'b0,   "R7");
    a_frc = 1'b0;
    t_bypass();
    t_reconfig();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule